// File: doc/BRIEF.md
# Vectored Interrupt Controller with Register Port

This block gathers up to 32 interrupt lines into one interrupt request for a processor. Each line is first synchronised to the controller clock. A parameter mask then marks each line as pulse-triggered, which latches on a rising edge, or state-triggered, which latches on every cycle the line is high. Latched lines collect in a status register. A pending view is formed by masking the status register with an enable register. The lowest-numbered pending line is reported as a vector. The output request is a registered signal, gated by a two-bit master control register.

Software reaches the block through a 32-bit word-addressed register port that uses a valid/ready handshake. The enable register can be written whole, or changed bit by bit through a set alias and a clear alias. Status bits are cleared by writing ones to an acknowledge register. Until the hardware-enable bit of the master control register is set, software may also raise status bits directly to test the interrupt path. That bit is sticky until reset. If a kind mask has bits above the configured line count, elaboration is rejected.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, status, enable and master control read as zero, and `irq_out` is low.
- R2: A pulse-triggered line (kind bit 1; the default mask 0x0F makes lines 0 to 3 pulse-triggered) sets its status bit once per rising edge of its synchronised level. A line held high after an acknowledge does not set the bit again.
- R3: A state-triggered line (kind bit 0) sets its status bit on every cycle its synchronised level is high. An acknowledge has no lasting effect while the line stays high.
- R4: Writing byte offset 0x08 replaces the enable register. Writing 0x10 ORs the data into it. Writing 0x14 clears the enable bits where the data holds a 1.
- R5: Offset 0x04 reads status AND enable. Offset 0x00 reads the raw status, whatever the enables are.
- R6: Writing offset 0x0C clears every status bit whose data bit is 1. Writing all ones clears all bits that no line is driving at that moment.
- R7: Offset 0x18 reads the index of the lowest-numbered pending line, where line 0 has the highest priority. With nothing pending it reads 0xFFFFFFFF.
- R8: Offset 0x1C holds the master enable in bit 0 and the hardware enable in bit 1. `irq_out` is high one cycle after both bits are 1 and pending is non-zero, and low otherwise.
- R9: Once written to 1, the hardware enable bit stays 1 until reset. The master enable bit follows each write.
- R10: While the hardware enable bit is 0, a write to offset 0x00 ORs the data into status. Once that bit is 1, such writes are ignored.
- R11: Offsets 0x0C, 0x10 and 0x14 read as zero. Register bits at or above the line count read as zero and ignore writes.
- R12: `bus_ready` goes high for exactly one cycle, in the cycle after `bus_valid` is first seen. `bus_rdata` is valid in that same cycle. The access takes effect at the edge that raises `bus_ready`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | N_IN | Asynchronous interrupt lines |
| bus_valid | input | 1 | Register access request; held until `bus_ready` |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Access complete; one-cycle pulse |
| bus_rdata | output | 32 | Read data, valid while `bus_ready` is high |
| irq_out | output | 1 | Registered interrupt request to the processor |

## Verification
The embedded assertions check these on every cycle: the master gating of `irq_out`, the stickiness of the hardware enable, that no status bit appears from a locked software write, that acknowledges clear and line hits set, the set-alias effect on enables, the one-cycle ready pulse, and the one-shot nature of edge hits. Only the bench's scenarios can show the register semantics that need values read back. These include the enable alias arithmetic under random sequences, the pending and vector values with their priority order, the all-ones empty vector, the zero reads of the aliases, and the difference between acknowledging an edge line and a level line that stays high.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int BUS_W  = 32;
    localparam int ADDR_W = 5;
    localparam int IDX_W  = 5;

    // Word slot decoded from byte offset bits [4:2]
    typedef enum logic [2:0] {
        SLOT_STAT = 3'd0,
        SLOT_PEND = 3'd1,
        SLOT_ENAB = 3'd2,
        SLOT_ACK  = 3'd3,
        SLOT_SETE = 3'd4,
        SLOT_CLRE = 3'd5,
        SLOT_VECT = 3'd6,
        SLOT_MCTL = 3'd7
    } slot_e;

    typedef struct packed {
        logic hie;   // hardware enable, sticky
        logic me;    // master enable
    } mctl_t;

    typedef struct packed {
        logic                   found;
        logic [IDX_W-1:0]       idx;
    } vec_t;

    function automatic slot_e decode_slot(input logic [ADDR_W-1:0] addr);
        return slot_e'(addr[4:2]);
    endfunction

    function automatic logic [BUS_W-1:0] vec_word(input vec_t v);
        logic [BUS_W-1:0] w;
        w = '1;
        if (v.found) begin
            w = '0;
            w[IDX_W-1:0] = v.idx;
        end
        return w;
    endfunction

endpackage

// File: rtl/irqc_sync_stage.sv
module irqc_sync_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d;
            sync_q <= meta_q;
        end
    end

    assign q = sync_q;
endmodule

// File: rtl/irqc_src_detect.sv
module irqc_src_detect #(
    parameter int          N_IN      = 8,
    parameter logic [31:0] EDGE_MASK = 32'h0000_000F
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N_IN-1:0] lvl,
    output logic [N_IN-1:0] hit
);
    genvar i;
    generate
        for (i = 0; i < N_IN; i++) begin : g_src
            if (EDGE_MASK[i]) begin : g_edge
                logic prev_q;
                always_ff @(posedge clk) begin
                    if (rst) prev_q <= 1'b0;
                    else     prev_q <= lvl[i];
                end
                assign hit[i] = lvl[i] & ~prev_q;

                AST_EDGE_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
                    hit[i] |=> !hit[i]); // R2
            end else begin : g_level
                assign hit[i] = lvl[i];
            end
        end
    endgenerate
endmodule

// File: rtl/irqc_prio_enc.sv
module irqc_prio_enc
    import irqc_pkg::*;
#(
    parameter int N_IN = 8
) (
    input  logic [N_IN-1:0] req,
    output vec_t            vec
);
    always_comb begin
        vec = '0;
        for (int k = N_IN - 1; k >= 0; k--) begin
            if (req[k]) begin
                vec.found = 1'b1;
                vec.idx   = IDX_W'(k);
            end
        end
    end
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
    import irqc_pkg::*;
#(
    parameter int          N_IN      = 8,
    parameter logic [31:0] EDGE_MASK = 32'h0000_000F
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_IN-1:0]   irq_in,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic              bus_ready,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              irq_out
);
    localparam logic [31:0] LINE_BITS =
        (N_IN >= 32) ? 32'hFFFF_FFFF : ((32'd1 << N_IN) - 32'd1);

    generate
        if (N_IN < 1 || N_IN > 32) begin : g_bad_count
            $error("vec_irq_ctrl: N_IN must be 1..32");
        end
        if ((EDGE_MASK & ~LINE_BITS) != 32'd0) begin : g_bad_kind
            $error("vec_irq_ctrl: EDGE_MASK has bits above N_IN");
        end
    endgenerate

    // Line front end
    logic [N_IN-1:0] in_sync;
    logic [N_IN-1:0] hit;

    irqc_sync_stage #(.W(N_IN)) i_sync (
        .clk (clk),
        .rst (rst),
        .d   (irq_in),
        .q   (in_sync)
    );

    irqc_src_detect #(.N_IN(N_IN), .EDGE_MASK(EDGE_MASK)) i_detect (
        .clk (clk),
        .rst (rst),
        .lvl (in_sync),
        .hit (hit)
    );

    // Register state
    logic [N_IN-1:0]  status_q;
    logic [N_IN-1:0]  enable_q;
    mctl_t            mctl_q;
    logic             ready_q;
    logic [BUS_W-1:0] rdata_q;
    logic             irq_q;

    // Access decode
    logic            accept;
    slot_e           slot;
    logic [N_IN-1:0] wmask;
    logic            wr_stat, wr_enab, wr_ack, wr_sete, wr_clre, wr_mctl;

    assign accept  = bus_valid & ~ready_q;
    assign slot    = decode_slot(bus_addr);
    assign wmask   = bus_wdata[N_IN-1:0];
    assign wr_stat = accept & bus_write & (slot == SLOT_STAT);
    assign wr_enab = accept & bus_write & (slot == SLOT_ENAB);
    assign wr_ack  = accept & bus_write & (slot == SLOT_ACK);
    assign wr_sete = accept & bus_write & (slot == SLOT_SETE);
    assign wr_clre = accept & bus_write & (slot == SLOT_CLRE);
    assign wr_mctl = accept & bus_write & (slot == SLOT_MCTL);

    // Pending and vector
    logic [N_IN-1:0] pend;
    vec_t            vec;

    assign pend = status_q & enable_q;

    irqc_prio_enc #(.N_IN(N_IN)) i_prio (
        .req (pend),
        .vec (vec)
    );

    // Status next state: hits win over acknowledge
    logic [N_IN-1:0] stat_clr, stat_sw, status_d;

    always_comb begin
        stat_clr = wr_ack ? wmask : '0;
        stat_sw  = (wr_stat && !mctl_q.hie) ? wmask : '0;
        status_d = (status_q & ~stat_clr) | stat_sw | hit;
    end

    // Enable next state
    logic [N_IN-1:0] enable_d;

    always_comb begin
        enable_d = enable_q;
        if (wr_enab)      enable_d = wmask;
        else if (wr_sete) enable_d = enable_q | wmask;
        else if (wr_clre) enable_d = enable_q & ~wmask;
    end

    // Read mux
    logic [BUS_W-1:0] stat_w, pend_w, enab_w, mctl_w, rd_mux;

    always_comb begin
        stat_w = '0;
        pend_w = '0;
        enab_w = '0;
        mctl_w = '0;
        stat_w[N_IN-1:0] = status_q;
        pend_w[N_IN-1:0] = pend;
        enab_w[N_IN-1:0] = enable_q;
        mctl_w[1:0]      = mctl_q;
        unique case (slot)
            SLOT_STAT: rd_mux = stat_w;
            SLOT_PEND: rd_mux = pend_w;
            SLOT_ENAB: rd_mux = enab_w;
            SLOT_VECT: rd_mux = vec_word(vec);
            SLOT_MCTL: rd_mux = mctl_w;
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            enable_q <= '0;
            mctl_q   <= '0;
            ready_q  <= 1'b0;
            rdata_q  <= '0;
            irq_q    <= 1'b0;
        end else begin
            status_q <= status_d;
            enable_q <= enable_d;
            if (wr_mctl) begin
                mctl_q.me  <= bus_wdata[0];
                mctl_q.hie <= mctl_q.hie | bus_wdata[1];
            end
            ready_q <= accept;
            if (accept && !bus_write) rdata_q <= rd_mux;
            else if (accept)          rdata_q <= '0;
            irq_q <= mctl_q.me & mctl_q.hie & (|pend);
        end
    end

    assign bus_ready = ready_q;
    assign bus_rdata = rdata_q;
    assign irq_out   = irq_q;

    // Assertions
    AST_MASTER_GATE: assert property (@(posedge clk) disable iff (rst)
        !(mctl_q.me && mctl_q.hie) |=> !irq_out); // R8
    AST_NO_PEND_NO_IRQ: assert property (@(posedge clk) disable iff (rst)
        (pend == '0) |=> !irq_out); // R8
    AST_HIE_STICKY: assert property (@(posedge clk) disable iff (rst)
        mctl_q.hie |=> mctl_q.hie); // R9
    AST_SW_LOCKED: assert property (@(posedge clk) disable iff (rst)
        mctl_q.hie |=> ((status_q & ~$past(status_q) & ~$past(hit)) == '0)); // R10
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        wr_ack |=> ((status_q & $past(wmask & ~hit)) == '0)); // R6
    AST_HIT_SETS: assert property (@(posedge clk) disable iff (rst)
        (hit != '0) |=> ((status_q & $past(hit)) == $past(hit))); // R3
    AST_SET_ALIAS: assert property (@(posedge clk) disable iff (rst)
        wr_sete |=> ((enable_q & $past(wmask)) == $past(wmask))); // R4
    AST_READY_PULSE: assert property (@(posedge clk) disable iff (rst)
        bus_ready |=> !bus_ready); // R12
    AST_VEC_PENDING: assert property (@(posedge clk) disable iff (rst)
        vec.found |-> pend[vec.idx]); // R7
endmodule

// File: tb/test_vec_irq_ctrl.sv
module test_vec_irq_ctrl;
    localparam int N = 8;

    localparam logic [4:0] A_STAT = 5'h00, A_PEND = 5'h04, A_ENAB = 5'h08, A_ACK = 5'h0C,
                           A_SETE = 5'h10, A_CLRE = 5'h14, A_VECT = 5'h18, A_MCTL = 5'h1C;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  irq_in = '0;
    logic          bus_valid = 1'b0;
    logic          bus_write = 1'b0;
    logic [4:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic          bus_ready;
    logic [31:0]   bus_rdata;
    logic          irq_out;

    int n_checks = 0;
    int n_fail   = 0;
    int hs_bad   = 0;

    always #5 clk = ~clk;

    vec_irq_ctrl #(.N_IN(N), .EDGE_MASK(32'h0000_000F)) i_vec_irq_ctrl (
        .clk(clk), .rst(rst), .irq_in(irq_in),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_rdata(bus_rdata),
        .irq_out(irq_out)
    );

    function automatic logic [31:0] exp_vec(input logic [N-1:0] p);
        for (int k = 0; k < N; k++) if (p[k]) return 32'(k);
        return 32'hFFFF_FFFF;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_xfer(input logic wr, input logic [4:0] a, input logic [31:0] d,
                            output logic [31:0] r);
        logic ok;
        @(negedge clk);
        bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        ok = bus_ready;
        r  = bus_rdata;
        bus_valid = 1'b0;
        @(negedge clk);
        if (bus_ready) ok = 1'b0;
        if (!ok) hs_bad++;
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        logic [31:0] dummy;
        bus_xfer(1'b1, a, d, dummy);
    endtask

    task automatic rd_check(input string req, input logic [4:0] a, input logic [31:0] exp);
        logic [31:0] r;
        bus_xfer(1'b0, a, '0, r);
        check(req, r, exp);
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : main
        logic [N-1:0] m_en, m_st;
        logic [31:0]  d;
        int           op;
        void'($urandom(32'd20240611));

        repeat (3) @(negedge clk);
        rst = 1'b0;
        settle(2);

        // R1 reset state
        check("R1 irq_out", 32'(irq_out), 32'd0);
        rd_check("R1 status", A_STAT, 32'd0);
        rd_check("R1 enable", A_ENAB, 32'd0);
        rd_check("R1 master", A_MCTL, 32'd0);
        rd_check("R7 empty vector", A_VECT, 32'hFFFF_FFFF);

        // Random register traffic, lines quiet, HIE still 0
        m_en = '0; m_st = '0;
        for (int it = 0; it < 40; it++) begin
            op = int'($urandom_range(0, 4));
            d  = $urandom;
            case (op)
                0: begin wr(A_ENAB, d); m_en = d[N-1:0]; end
                1: begin wr(A_SETE, d); m_en = m_en | d[N-1:0]; end
                2: begin wr(A_CLRE, d); m_en = m_en & ~d[N-1:0]; end
                3: begin wr(A_STAT, d); m_st = m_st | d[N-1:0]; end // R10 sw set
                default: begin wr(A_ACK, d); m_st = m_st & ~d[N-1:0]; end // R6
            endcase
            rd_check("R10 status", A_STAT, {24'd0, m_st});
            rd_check("R4 enable", A_ENAB, {24'd0, m_en});
            rd_check("R5 pending", A_PEND, {24'd0, m_st & m_en});
            rd_check("R7 vector", A_VECT, exp_vec(m_st & m_en));
            check("R8 irq off while master 0", 32'(irq_out), 32'd0);
            if (it % 8 == 0) begin
                rd_check("R11 ack alias reads 0", A_ACK, 32'd0);
                rd_check("R11 set alias reads 0", A_SETE, 32'd0);
                rd_check("R11 clr alias reads 0", A_CLRE, 32'd0);
            end
        end

        // Master control gating
        wr(A_ACK, 32'hFFFF_FFFF);
        wr(A_ENAB, 32'h10);
        wr(A_STAT, 32'h10);
        wr(A_MCTL, 32'h1);
        settle(3);
        check("R8 ME only", 32'(irq_out), 32'd0);
        wr(A_MCTL, 32'h3);
        settle(2);
        check("R8 ME and HIE", 32'(irq_out), 32'd1);
        rd_check("R7 vector sw", A_VECT, 32'd4);
        wr(A_MCTL, 32'h0);
        rd_check("R9 HIE sticky", A_MCTL, 32'h2);
        settle(2);
        check("R8 ME cleared", 32'(irq_out), 32'd0);
        wr(A_MCTL, 32'h1);
        rd_check("R9 ME follows", A_MCTL, 32'h3);
        settle(2);
        check("R8 irq back", 32'(irq_out), 32'd1);

        // Software status locked once HIE set
        wr(A_ACK, 32'hFFFF_FFFF);
        settle(2);
        check("R6 irq drops after ack", 32'(irq_out), 32'd0);
        wr(A_STAT, 32'hFF);
        rd_check("R10 locked status write", A_STAT, 32'd0);

        // Upper bits
        wr(A_ENAB, 32'hFFFF_FFFF);
        rd_check("R11 upper enable bits", A_ENAB, 32'hFF);

        // Edge line 1
        @(negedge clk); irq_in[1] = 1'b1;
        settle(5);
        rd_check("R2 edge latched", A_STAT, 32'h02);
        rd_check("R7 vector edge", A_VECT, 32'd1);
        check("R8 irq edge", 32'(irq_out), 32'd1);
        wr(A_ACK, 32'h02);
        settle(5);
        rd_check("R2 held edge no refire", A_STAT, 32'd0);
        @(negedge clk); irq_in[1] = 1'b0;
        settle(4);
        @(negedge clk); irq_in[1] = 1'b1;
        settle(5);
        rd_check("R2 new edge latched", A_STAT, 32'h02);
        @(negedge clk); irq_in[1] = 1'b0;
        wr(A_ACK, 32'h02);

        // Level line 5
        @(negedge clk); irq_in[5] = 1'b1;
        settle(5);
        rd_check("R3 level latched", A_STAT, 32'h20);
        wr(A_ACK, 32'hFFFF_FFFF);
        settle(2);
        rd_check("R3 level re-sets after ack", A_STAT, 32'h20);
        @(negedge clk); irq_in[5] = 1'b0;
        settle(4);
        wr(A_ACK, 32'h20);
        rd_check("R3 level cleared when low", A_STAT, 32'd0);

        // Priority with edge 2 and level 6
        @(negedge clk); irq_in[6] = 1'b1; irq_in[2] = 1'b1;
        settle(5);
        rd_check("R7 lowest wins", A_VECT, 32'd2);
        wr(A_ACK, 32'h04);
        rd_check("R7 next pending", A_VECT, 32'd6);
        wr(A_CLRE, 32'h40);
        rd_check("R5 masked pending", A_PEND, 32'd0);
        rd_check("R5 status unmasked", A_STAT, 32'h40);
        rd_check("R7 masked vector", A_VECT, 32'hFFFF_FFFF);
        settle(2);
        check("R8 masked irq", 32'(irq_out), 32'd0);
        @(negedge clk); irq_in = '0;
        settle(4);
        wr(A_ACK, 32'hFFFF_FFFF);
        rd_check("R6 all cleared", A_STAT, 32'd0);

        check("R12 handshake pulses", 32'(hs_bad), 32'd0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule